// File: doc/BRIEF.md
# Four-Channel Low-Side Driver Mode and Fault Controller

This block holds the operating state of four identical low-side output channels. A 16-bit command word arrives with a one-cycle write strobe. Each channel takes its own 2-bit field from the low byte and enters one of four modes: quiet standby, following a parallel pin, forced on, or off with the load-check current enabled. From the mode, the parallel pin and its latched faults, each channel produces a gate-on signal for its driver and an enable for the open-load diagnostic sink current.

Each channel keeps two sticky fault flags. The drive-fault flag is set by an overload that lasts through a programmable filter delay, or at once by an overtemperature event. While it is set, the output is held off until a standby command clears it. The open-load flag is set only while the driver is off and the diagnostic current is on. It never blocks the output.

A limp-home input takes command away from the serial port. While it is high, every output follows its parallel pin and command writes are ignored, but faults still latch. When it falls, every channel goes back to its power-up state. The analog comparators are modelled as synchronous digital inputs.

Top module: `lsd_chan_bank`

## Requirements
- R1: Field value 00 (standby) forces gate off and diagnostic current off; writing 00 to a channel clears both of that channel's fault flags.
- R2: Field value 01 (pin mode) makes the gate follow that channel's bit of `par_in` in the same cycle; the diagnostic current is on exactly while the gate is off.
- R3: Field value 10 turns the gate on with the diagnostic current off.
- R4: Field value 11 holds the gate off with the diagnostic current on. After reset or limp-home exit the mode reads as 11, but the diagnostic current stays off until the next accepted write.
- R5: Channel n (0..3) takes its field from `cmd_word[2n+1:2n]`. Bits 15..8 have no effect on any output.
- R6: After reset, all gates, diagnostic enables and fault flags are 0.
- R7: An overload that is high for OVL_FILT consecutive clock edges while the gate is on sets `drv_flag` at the last of those edges and forces the gate off. A shorter run restarts the filter. The gate stays off through non-standby writes until a standby write clears the flag.
- R8: An overtemperature input sets that channel's `drv_flag` at the next edge and turns its gate off. Other channels are unaffected.
- R9: Open load sets `ol_flag` only in a cycle where the diagnostic current is enabled. A set `ol_flag` does not stop the gate turning on.
- R10: While `limp` is high, each gate follows `par_in` (unless its drive fault is set), the diagnostic current is on while the gate is off, and writes are ignored. At the edge after `limp` falls, all channels return to the reset state with their flags cleared.
- R11: If a fault sets in the same cycle as a clear, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low global reset |
| cmd_word | input | 16 | Command word, 2 bits per channel in the low byte |
| cmd_wr | input | 1 | One-cycle strobe that applies `cmd_word` |
| par_in | input | 4 | Parallel control pins, one per channel |
| limp | input | 1 | Limp-home request |
| ovl_in | input | 4 | Overload comparator outputs |
| otemp_in | input | 4 | Overtemperature comparator outputs |
| open_in | input | 4 | Open-load comparator outputs |
| gate_on | output | 4 | Driver gate-on per channel |
| diag_en | output | 4 | Diagnostic sink current enable per channel |
| ol_flag | output | 4 | Latched open-load flag per channel |
| drv_flag | output | 4 | Latched overload/overtemperature flag per channel |

## Verification
A vector table writes command words in which all four channels share one mode and words in which each channel has a different mode. In pin mode it applies alternating pin patterns, which show that each field reaches only its own channel and that pin mode tracks the pin in both directions. One row carries junk in the high byte to show that those bits are ignored. Directed sequences then check overload runs one edge short of and exactly at the filter length, an overtemperature pulse while neighbours stay on, and open-load pulses on an off channel and on an on channel. They also cover a clear that collides with a new fault, and limp-home entry, write rejection and exit.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
  typedef enum logic [1:0] {
    M_STBY  = 2'b00,
    M_INPUT = 2'b01,
    M_ON    = 2'b10,
    M_OFF   = 2'b11
  } chan_mode_e;

  // Field of channel ch inside a command word (2 bits per channel, ch 0 at LSB)
  function automatic logic [1:0] cmd_field(input logic [15:0] w, input int unsigned ch);
    return w[2*ch +: 2];
  endfunction

  // Whether the mode requests the driver on, before faults are applied
  function automatic logic want_on(input chan_mode_e m, input logic pin);
    case (m)
      M_INPUT: return pin;
      M_ON:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Diagnostic sink current request for a given mode and final gate state
  function automatic logic diag_wanted(input chan_mode_e m, input logic pu_quiet,
                                       input logic gate);
    case (m)
      M_INPUT: return !gate;
      M_OFF:   return !pu_quiet;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/lsd_ovl_filter.sv
module lsd_ovl_filter #(
  parameter int unsigned FILT = 375000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic trip
);
  localparam int unsigned CW = (FILT < 2) ? 1 : $clog2(FILT + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT - 1);

  logic [CW-1:0] cnt_q;

  assign trip = arm && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!arm||trip) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  // R7: the run counter never passes the filter length
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R7: a dropped overload restarts the filter
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> cnt_q == '0);
endmodule

// File: rtl/lsd_flag_latch.sv
module lsd_flag_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  // R11: a new fault beats a simultaneous clear
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);

  // R1: a clear with no new fault leaves the flag low
  a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q);
endmodule

// File: rtl/lsd_chan_ctrl.sv
module lsd_chan_ctrl
  import lsd_pkg::*;
#(
  parameter int unsigned CH   = 0,
  parameter int unsigned FILT = 375000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cmd_word,
  input  logic        cmd_wr,
  input  logic        limp,
  input  logic        reinit,
  input  logic        pin,
  input  logic        ovl,
  input  logic        otemp,
  input  logic        open_cmp,
  output logic        gate,
  output logic        diag,
  output logic        ol_flag,
  output logic        drv_flag
);
  chan_mode_e mode_q;
  logic       pu_quiet_q;
  logic       wr_ok;
  logic [1:0] fld;
  logic       clr_faults;
  logic       want;
  logic       ovl_arm;
  logic       ovl_trip;
  logic       drv_set;
  logic       ol_set;

  assign fld        = cmd_field(cmd_word, CH);
  assign wr_ok      = cmd_wr && !limp;
  assign clr_faults = (wr_ok && fld == M_STBY) || reinit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= M_OFF;
      pu_quiet_q <= 1'b1;
    end else if (reinit) begin
      mode_q     <= M_OFF;
      pu_quiet_q <= 1'b1;
    end else if (wr_ok) begin
      mode_q     <= chan_mode_e'(fld);
      pu_quiet_q <= 1'b0;
    end
  end

  assign want    = limp ? pin : want_on(mode_q, pin);
  assign gate    = want && !drv_flag;
  assign diag    = limp ? !gate : diag_wanted(mode_q, pu_quiet_q, gate);

  assign ovl_arm = ovl && gate;
  assign drv_set = otemp || ovl_trip;
  assign ol_set  = open_cmp && diag;

  lsd_ovl_filter #(.FILT(FILT)) u_filt (
    .clk  (clk),
    .rst_n(rst_n),
    .arm  (ovl_arm),
    .trip (ovl_trip)
  );

  lsd_flag_latch u_drv (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (drv_set),
    .clr  (clr_faults),
    .q    (drv_flag)
  );

  lsd_flag_latch u_ol (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (ol_set),
    .clr  (clr_faults),
    .q    (ol_flag)
  );

  // R1: standby outside limp-home is fully quiet
  a_r1_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!limp && mode_q == M_STBY) |-> (!gate && !diag));

  // R7: a filter expiry latches the fault and drops the gate
  a_r7_trip_latch: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_trip |=> (drv_flag && !gate));

  // R9: open load is only recorded while the driver is off
  a_r9_ol_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    ol_set |-> !gate);

  // R10: writes during limp-home leave the mode untouched
  a_r10_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (limp && cmd_wr && !reinit) |=> mode_q == $past(mode_q));

  // R4: limp-home exit returns to the quiet power-up off state
  a_r4_reinit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |=> (mode_q == M_OFF && pu_quiet_q));
endmodule

// File: rtl/lsd_chan_bank.sv
module lsd_chan_bank #(
  parameter int unsigned NCH      = 4,
  parameter int unsigned OVL_FILT = 375000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [15:0]    cmd_word,
  input  logic           cmd_wr,
  input  logic [NCH-1:0] par_in,
  input  logic           limp,
  input  logic [NCH-1:0] ovl_in,
  input  logic [NCH-1:0] otemp_in,
  input  logic [NCH-1:0] open_in,
  output logic [NCH-1:0] gate_on,
  output logic [NCH-1:0] diag_en,
  output logic [NCH-1:0] ol_flag,
  output logic [NCH-1:0] drv_flag
);
  logic limp_q;
  logic limp_exit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) limp_q <= 1'b0;
    else        limp_q <= limp;
  end

  assign limp_exit = limp_q && !limp;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    lsd_chan_ctrl #(.CH(i), .FILT(OVL_FILT)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd_word(cmd_word),
      .cmd_wr  (cmd_wr),
      .limp    (limp),
      .reinit  (limp_exit),
      .pin     (par_in[i]),
      .ovl     (ovl_in[i]),
      .otemp   (otemp_in[i]),
      .open_cmp(open_in[i]),
      .gate    (gate_on[i]),
      .diag    (diag_en[i]),
      .ol_flag (ol_flag[i]),
      .drv_flag(drv_flag[i])
    );
  end

  // R10: one edge after limp-home exit every flag is clear
  a_r10_exit_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (limp_exit && ovl_in == '0 && otemp_in == '0 && open_in == '0)
      |=> (drv_flag == '0 && ol_flag == '0));

  // R8: overtemperature latches the drive fault on the next edge
  a_r8_otemp_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (otemp_in != '0) |=> ((drv_flag & $past(otemp_in)) == $past(otemp_in)));
endmodule

// File: tb/sim_lsd_chan_bank.sv
module sim_lsd_chan_bank;
  localparam int unsigned FILT = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cmd_word = '0;
  logic        cmd_wr = 1'b0;
  logic [3:0]  par_in = '0;
  logic        limp = 1'b0;
  logic [3:0]  ovl_in = '0;
  logic [3:0]  otemp_in = '0;
  logic [3:0]  open_in = '0;
  logic [3:0]  gate_on, diag_en, ol_flag, drv_flag;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  lsd_chan_bank #(.NCH(4), .OVL_FILT(FILT)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .cmd_wr(cmd_wr),
    .par_in(par_in), .limp(limp), .ovl_in(ovl_in), .otemp_in(otemp_in),
    .open_in(open_in), .gate_on(gate_on), .diag_en(diag_en),
    .ol_flag(ol_flag), .drv_flag(drv_flag)
  );

  // {cmd_word, par_in, expected gate_on, expected diag_en}
  // rows exercise R1, R2, R3, R4 and R5; bit n of each nibble is channel n
  localparam int NV = 8;
  localparam logic [27:0] VEC [NV] = '{
    {16'h0000, 4'b0000, 4'b0000, 4'b0000},
    {16'hFFFF, 4'b0000, 4'b0000, 4'b1111},
    {16'h00AA, 4'b0000, 4'b1111, 4'b0000},
    {16'h0055, 4'b0101, 4'b0101, 4'b1010},
    {16'h0055, 4'b1010, 4'b1010, 4'b0101},
    {16'h00E4, 4'b0010, 4'b0110, 4'b1000},
    {16'hFF1B, 4'b0000, 4'b0010, 4'b0101},
    {16'h5AAA, 4'b0000, 4'b1111, 4'b0000}
  };

  task automatic chk(input string req, input string what,
                     input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic wr_cmd(input logic [15:0] w);
    @(negedge clk);
    cmd_word = w;
    cmd_wr   = 1'b1;
    @(negedge clk);
    cmd_wr   = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 / R4: power-up state is fully quiet
    chk("R6", "reset gate", gate_on, 4'b0000);
    chk("R4", "reset diag off", diag_en, 4'b0000);
    chk("R6", "reset ol", ol_flag, 4'b0000);
    chk("R6", "reset drv", drv_flag, 4'b0000);

    // vector table
    for (int i = 0; i < NV; i++) begin
      wr_cmd(VEC[i][27:12]);
      par_in = VEC[i][11:8];
      #1;
      chk("table", $sformatf("row %0d gate", i), gate_on, VEC[i][7:4]);
      chk("table", $sformatf("row %0d diag", i), diag_en, VEC[i][3:0]);
    end
    par_in = '0;

    // R7: overload filter, all channels on
    wr_cmd(16'h00AA);
    ovl_in = 4'b0001;
    repeat (FILT - 1) @(negedge clk);
    ovl_in = 4'b0000;
    @(negedge clk);
    chk("R7", "short overload drv", drv_flag, 4'b0000);
    chk("R7", "short overload gate", gate_on, 4'b1111);
    ovl_in = 4'b0001;
    repeat (FILT - 1) @(negedge clk);
    chk("R7", "one edge early drv", drv_flag, 4'b0000);
    @(negedge clk);
    ovl_in = 4'b0000;
    chk("R7", "filter expiry drv", drv_flag, 4'b0001);
    chk("R7", "filter expiry gate", gate_on, 4'b1110);
    wr_cmd(16'h00AA);
    chk("R7", "on write keeps off", gate_on, 4'b1110);
    wr_cmd(16'h00A8);
    chk("R1", "standby clears drv", drv_flag, 4'b0000);
    wr_cmd(16'h00AA);
    chk("R7", "gate back after clear", gate_on, 4'b1111);

    // R8: overtemperature pulse on channel 2
    @(negedge clk);
    otemp_in = 4'b0100;
    @(negedge clk);
    otemp_in = 4'b0000;
    chk("R8", "otemp drv", drv_flag, 4'b0100);
    chk("R8", "otemp gate isolated", gate_on, 4'b1011);

    // R11: standby write to channel 2 collides with a new overtemperature
    @(negedge clk);
    cmd_word = 16'h008A;
    cmd_wr   = 1'b1;
    otemp_in = 4'b0100;
    @(negedge clk);
    cmd_wr   = 1'b0;
    otemp_in = 4'b0000;
    chk("R11", "set beats clear", drv_flag, 4'b0100);
    wr_cmd(16'h008A);
    chk("R1", "later clear", drv_flag, 4'b0000);
    wr_cmd(16'h00AA);

    // R9: open load on off channel 3 latches, on channel 1 is ignored
    wr_cmd(16'h00C8);
    @(negedge clk);
    open_in = 4'b1010;
    @(negedge clk);
    open_in = 4'b0000;
    chk("R9", "open-load flags", ol_flag, 4'b1000);
    wr_cmd(16'h0088);
    chk("R9", "gate on despite ol", gate_on, 4'b1010);
    chk("R9", "ol kept", ol_flag, 4'b1000);

    // R10: limp-home
    @(negedge clk);
    limp   = 1'b1;
    par_in = 4'b0101;
    #1;
    chk("R10", "limp gate", gate_on, 4'b0101);
    chk("R10", "limp diag", diag_en, 4'b1010);
    wr_cmd(16'h0000);
    chk("R10", "write ignored gate", gate_on, 4'b0101);
    chk("R10", "write ignored ol", ol_flag, 4'b1000);
    limp = 1'b0;
    @(negedge clk);
    chk("R10", "exit gate", gate_on, 4'b0000);
    chk("R4", "exit diag quiet", diag_en, 4'b0000);
    chk("R10", "exit ol cleared", ol_flag, 4'b0000);
    wr_cmd(16'hFFFF);
    chk("R4", "diag after write", diag_en, 4'b1111);

    finish_run();
  end
endmodule